// File: doc/BRIEF.md
# History-Correlated Branch Direction and Target Predictor

This block sits in the fetch stage and turns a fetch address into the address to fetch next. Direction comes from a table of 2-bit saturating counters. The table row is chosen by low word-address bits of the fetch address, and the column by a 2-bit global history of recent resolved outcomes. The target comes from a small fully associative target store. Each entry in that store keeps the whole branch address, so a match means the entry belongs to that branch and no other. The next address is the stored target only when the target store hits and the counter predicts taken. In every other case it is the fetch address plus 4.

Lookups come in on a valid/ready stream and leave on a valid/ready stream. The prediction is combinational, so `lk_ready` equals `pr_ready`: a lookup is accepted in the same cycle its prediction is accepted. When `pr_ready` is low the lookup stalls, and the source must hold `lk_pc` stable while `lk_valid` is high. Resolved branches arrive on an update stream that is always ready (`up_ready` is tied high). Updates change state at the following clock edge, so a lookup in the same cycle as an update sees the old state.

Top module: `bp2lvl_top`

## Requirements
- R1: After reset every counter holds weakly not-taken (binary 01), the history is 00 and every target entry is invalid, so every lookup predicts not-taken with next PC = PC+4.
- R2: A counter moves up by one on a taken update and down by one on a not-taken update, and stays put at 11 and at 00. Bit 1 of the counter (values 10 and 11) means predict taken.
- R3: A counter is selected by row = pc[K+1:2] and column = history (2 bits). The selection uses the history value held in the cycle of the lookup or of the update.
- R4: Each accepted update shifts its outcome into the history: new history = {old[0], taken}.
- R5: A target hit requires a valid entry whose stored full 32-bit branch PC equals the lookup PC.
- R6: `pr_next_pc` equals the stored target when there is a hit and the counter predicts taken. Otherwise it equals lk_pc+4, which covers a miss and also a hit with a not-taken prediction.
- R7: A taken update writes its target into the entry that matches its PC. If no entry matches, it writes into the next allocation slot, taken in round-robin order. A not-taken update never allocates an entry and never changes target contents.
- R8: A lookup and an update in the same cycle: the lookup sees the state from before the update.
- R9: The handshake follows the stream rules. `pr_valid` equals `lk_valid`, `lk_ready` equals `pr_ready`, and `up_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| lk_valid | input | 1 | lookup request valid |
| lk_ready | output | 1 | lookup accepted |
| lk_pc | input | 32 | fetch PC |
| pr_valid | output | 1 | prediction valid |
| pr_ready | input | 1 | prediction consumer ready |
| pr_taken | output | 1 | counter predicts taken |
| pr_hit | output | 1 | target store hit |
| pr_next_pc | output | 32 | next fetch PC |
| up_valid | input | 1 | resolved branch valid |
| up_ready | output | 1 | always 1 |
| up_pc | input | 32 | resolved branch PC |
| up_taken | input | 1 | resolved outcome |
| up_target | input | 32 | resolved target |

## Verification
Suppose a counter is corrupted or mis-indexed. The bench sees it on `pr_taken` during the very next lookup of that row and history, because the read path is purely combinational. A wrong history shift causes the same kind of error one update later. It appears as a lookup that selects the wrong column. Target store faults show on `pr_hit` and `pr_next_pc`. Possible faults here are a bad match, allocation of an entry on a not-taken update, or a wrong replacement victim. All of them are visible on the first lookup of the affected PC.

// File: rtl/bp2lvl_pkg.sv
package bp2lvl_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam int HIST_W = 2;

  function automatic ctr_t ctr_step(input ctr_t c, input logic tk);
    if (tk) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp2lvl_hist.sv
module bp2lvl_hist
  import bp2lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              taken,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (upd) hist <= {hist[HIST_W-2:0], taken};
  end
endmodule

// File: rtl/bp2lvl_pht.sv
module bp2lvl_pht
  import bp2lvl_pkg::*;
#(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [K-1:0]      rd_row,
  input  logic [HIST_W-1:0] rd_col,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [K-1:0]      wr_row,
  input  logic [HIST_W-1:0] wr_col,
  input  logic              wr_taken
);
  localparam int ROWS = 1 << K;
  localparam int COLS = 1 << HIST_W;
  ctr_t tbl [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk) begin
        if (!rst_n) tbl[r][c] <= CTR_WNT;
        else if (wr_en && wr_row == K'(r) && wr_col == HIST_W'(c))
          tbl[r][c] <= ctr_step(tbl[r][c], wr_taken);
      end
    end
  end

  ctr_t rd_ctr;
  assign rd_ctr   = tbl[rd_row][rd_col];
  assign rd_taken = rd_ctr[1];
endmodule

// File: rtl/bp2lvl_btb.sv
module bp2lvl_btb #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_pc,
  output logic          rd_hit,
  output logic [AW-1:0] rd_tgt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_pc,
  input  logic [AW-1:0] wr_tgt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  logic [N-1:0]  vld;
  logic [AW-1:0] epc [N];
  logic [AW-1:0] etg [N];
  logic [IW-1:0] victim;
  logic [N-1:0]  rd_m, wr_m;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign rd_m[i] = vld[i] && (epc[i] == rd_pc);
    assign wr_m[i] = vld[i] && (epc[i] == wr_pc);
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_tgt = '0;
    for (int i = 0; i < N; i++)
      if (rd_m[i] && !rd_hit) begin
        rd_hit = 1'b1;
        rd_tgt = etg[i];
      end
  end

  logic          wr_any;
  logic [IW-1:0] wr_idx;
  always_comb begin
    wr_any = 1'b0;
    wr_idx = victim;
    for (int i = 0; i < N; i++)
      if (wr_m[i] && !wr_any) begin
        wr_any = 1'b1;
        wr_idx = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      victim <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
      if (!wr_any) victim <= (victim == IW'(N-1)) ? '0 : victim + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      epc[wr_idx] <= wr_pc;
      etg[wr_idx] <= wr_tgt;
    end
  end
endmodule

// File: rtl/bp2lvl_top.sv
module bp2lvl_top
  import bp2lvl_pkg::*;
#(
  parameter int K      = 4,
  parameter int BTB_N  = 4,
  parameter int AW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  output logic          lk_ready,
  input  logic [AW-1:0] lk_pc,
  output logic          pr_valid,
  input  logic          pr_ready,
  output logic          pr_taken,
  output logic          pr_hit,
  output logic [AW-1:0] pr_next_pc,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_pc,
  input  logic          up_taken,
  input  logic [AW-1:0] up_target
);
  logic [HIST_W-1:0] hist;
  logic              upd;
  logic [AW-1:0]     hit_tgt;

  assign up_ready = 1'b1;
  assign upd      = up_valid;

  bp2lvl_hist u_hist (
    .clk(clk), .rst_n(rst_n), .upd(upd), .taken(up_taken), .hist(hist)
  );

  bp2lvl_pht #(.K(K)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_row(lk_pc[K+1:2]), .rd_col(hist), .rd_taken(pr_taken),
    .wr_en(upd), .wr_row(up_pc[K+1:2]), .wr_col(hist), .wr_taken(up_taken)
  );

  bp2lvl_btb #(.N(BTB_N), .AW(AW)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(lk_pc), .rd_hit(pr_hit), .rd_tgt(hit_tgt),
    .wr_en(upd && up_taken), .wr_pc(up_pc), .wr_tgt(up_target)
  );

  assign pr_next_pc = (pr_hit && pr_taken) ? hit_tgt : lk_pc + AW'(4);
  assign pr_valid   = lk_valid;
  assign lk_ready   = pr_ready;
endmodule

// File: rtl/bp2lvl_chk.sv
module bp2lvl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_ready,
  input logic [AW-1:0] lk_pc,
  input logic          pr_valid,
  input logic          pr_ready,
  input logic          pr_taken,
  input logic          pr_hit,
  input logic [AW-1:0] pr_next_pc,
  input logic          up_ready,
  input logic [1:0]    hist,
  input logic          up_valid,
  input logic          up_taken
);
  p_miss_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pr_hit && pr_taken) |-> pr_next_pc == lk_pc + AW'(4));
  p_valid_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid == lk_valid) && (lk_ready == pr_ready) && up_ready);
  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist == {$past(hist[0]), $past(up_taken)});
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));
  p_reset_miss_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !pr_hit && !pr_taken);
endmodule

bind bp2lvl_top bp2lvl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_pc(lk_pc), .pr_valid(pr_valid), .pr_ready(pr_ready),
  .pr_taken(pr_taken), .pr_hit(pr_hit), .pr_next_pc(pr_next_pc),
  .up_ready(up_ready), .hist(hist), .up_valid(up_valid), .up_taken(up_taken)
);

// File: tb/bp2lvl_top_tb_top.sv
module bp2lvl_top_tb_top;
  localparam int K = 4, N = 4;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic lk_valid = 0, pr_ready = 0, up_valid = 0, up_taken = 0;
  logic [31:0] lk_pc = 0, up_pc = 0, up_target = 0;
  logic lk_ready, pr_valid, pr_taken, pr_hit, up_ready;
  logic [31:0] pr_next_pc;

  bp2lvl_top dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int mc [16][4];
  int mh;
  logic        mv [N];
  logic [31:0] mp [N], mt [N];
  int          mvic;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int mfind(logic [31:0] pc);
    for (int i = 0; i < N; i++) if (mv[i] && mp[i] == pc) return i;
    return -1;
  endfunction

  task automatic lookup_check(string r, logic [31:0] pc);
    int row, e;
    logic tk;
    lk_pc = pc; lk_valid = 1; pr_ready = 1;
    #1;
    row = int'(pc[K+1:2]);
    tk = mc[row][mh] >= 2;
    e = mfind(pc);
    chk(r, {31'd0, pr_taken}, {31'd0, tk});
    chk(r, {31'd0, pr_hit}, {31'd0, e >= 0});
    chk(r, pr_next_pc, (e >= 0 && tk) ? mt[e] : pc + 4);
  endtask

  task automatic model_upd(logic [31:0] pc, logic t, logic [31:0] tg);
    int row, e;
    row = int'(pc[K+1:2]);
    if (t) begin if (mc[row][mh] < 3) mc[row][mh]++; end
    else   begin if (mc[row][mh] > 0) mc[row][mh]--; end
    if (t) begin
      e = mfind(pc);
      if (e < 0) begin e = mvic; mvic = (mvic + 1) % N; end
      mv[e] = 1; mp[e] = pc; mt[e] = tg;
    end
    mh = ((mh << 1) | int'(t)) & 3;
  endtask

  task automatic update(logic [31:0] pc, logic t, logic [31:0] tg);
    @(negedge clk);
    up_pc = pc; up_taken = t; up_target = tg; up_valid = 1;
    @(posedge clk); #1;
    model_upd(pc, t, tg);
    up_valid = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pcs [6];
    for (int r = 0; r < 16; r++) for (int c = 0; c < 4; c++) mc[r][c] = 1;
    mh = 0; mvic = 0;
    for (int i = 0; i < N; i++) begin mv[i] = 0; mp[i] = 0; mt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 sweep over all rows
    for (int r = 0; r < 16; r++) lookup_check("R1", 32'h1000 + 32'(r*4));
    // R9 handshake
    lk_valid = 1; pr_ready = 0; #1;
    chk("R9", {30'd0, pr_valid, lk_ready}, 32'd2);
    chk("R9", {31'd0, up_ready}, 32'd1);
    pr_ready = 1;
    // R2/R4/R3: saturation sweep, history column moves
    for (int i = 0; i < 6; i++) begin
      update(32'h2000, 1, 32'h3000);
      lookup_check("R2", 32'h2000);
    end
    for (int i = 0; i < 6; i++) begin
      update(32'h2000, 0, 32'h0);
      lookup_check("R2", 32'h2000);
    end
    // R3 row/column independence sweep
    for (int r = 0; r < 16; r++) begin
      update(32'h4000 + 32'(r*4), (r % 3) != 0, 32'h5000 + 32'(r*16));
      lookup_check("R3", 32'h4000 + 32'(r*4));
      lookup_check("R3", 32'h4100 + 32'(r*4));
    end
    // R5: aliasing PC (same row) must not hit
    update(32'h6000, 1, 32'h7000);
    update(32'h6000, 1, 32'h7000);
    lookup_check("R5", 32'h6040);
    lookup_check("R6", 32'h6000);
    // R7: not-taken does not allocate, replacement round robin
    update(32'h8000, 0, 32'h9000);
    lookup_check("R7", 32'h8000);
    pcs = '{32'hA000, 32'hA104, 32'hA208, 32'hA30C, 32'hA410, 32'hA514};
    foreach (pcs[i]) update(pcs[i], 1, pcs[i] + 32'h40);
    foreach (pcs[i]) lookup_check("R7", pcs[i]);
    update(32'hA514, 1, 32'hBEEF0);
    lookup_check("R7", 32'hA514);
    // R8: same-cycle lookup sees old state
    @(negedge clk);
    up_pc = 32'hC000; up_taken = 1; up_target = 32'hD000; up_valid = 1;
    lookup_check("R8", 32'hC000);
    @(posedge clk); #1;
    model_upd(32'hC000, 1, 32'hD000); up_valid = 0;
    lookup_check("R8", 32'hC000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule